// File: doc/BRIEF.md
# Odd-Even Grouping Lane Interconnect

This block moves data between the lanes of a small SIMD datapath. Each of the `L` lanes (default 4) holds two words of an `2L`-element vector: lane k holds element k in its low slot and element k+L in its high slot. One transfer takes the whole vector in over two input beats, reorders it, and returns it over two output beats. The block has three orderings: straight pass-through, the odd-even grouping (all even-indexed elements first, then all odd-indexed ones), and broadcast of one lane's word pair to every lane.

There is no crossbar. The `2L` words sit in a ring of pipeline registers in which each register is loaded only from its neighbour. The ring rotates one place per cycle for `2L` cycles. Each destination slot has a capture register that takes the word passing its position in the one rotation step that brings the wanted element there. Wiring per slot is therefore one neighbour link plus one local tap, for any permutation or broadcast. The block holds off new requests until the current transfer has left.

Top module: `oeg_net`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` and `out_done` are 0 and `out_data` is all zeros.
- R2: A transfer starts on a rising edge where `in_valid` and `in_ready` are both 1. That edge loads element k from lane k of `in_data`. The next edge loads element k+L from lane k, whatever `in_valid` is on that cycle.
- R3: `in_mode` and `in_src` are sampled only on the starting edge. Values present on any other cycle of the transfer do not change its result.
- R4: `in_mode` 0 and 3 select pass-through: output slot p gets element p.
- R5: `in_mode` 1 selects odd-even grouping. Output slot p gets element 2p for p < L and element 2(p-L)+1 for p >= L. For L=4 the order is 0,2,4,6,1,3,5,7.
- R6: `in_mode` 2 selects broadcast. Output slot k gets element `in_src` and slot k+L gets element `in_src`+L, for every lane k.
- R7: The first output beat comes 9 rising edges after the starting edge, with `out_valid`=1 and `out_done`=0. In that beat lane k of `out_data` carries slot k. The second beat follows on the next cycle, with `out_valid`=1 and `out_done`=1. In that beat lane k carries slot k+L.
- R8: `out_valid` is 0 on every other cycle, and `out_data` is all zeros whenever `out_valid` is 0.
- R9: `in_ready` is 0 from the cycle after the starting edge up to and including the second output beat, and is 1 on the cycle after it. A request presented while `in_ready` is 0 is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request to start a transfer |
| in_ready | output | 1 | Block is idle and can accept a transfer |
| in_mode | input | 2 | Ordering: 0/3 pass, 1 odd-even, 2 broadcast |
| in_src | input | $clog2(L) | Source lane for broadcast |
| in_data | input | L*W | One word per lane; lane k in bits k*W +: W |
| out_valid | output | 1 | Output beat present |
| out_done | output | 1 | Second and last beat of a transfer |
| out_data | output | L*W | One word per lane; lane k in bits k*W +: W |

## Verification
The hardest case to reach is a request that keeps pressing while a transfer is in progress. In the same run the second input beat arrives with `in_valid` low, and mode, source and data inputs keep changing. The bench holds `in_valid` high for the whole busy window while it drives random mode, source and data on every cycle after the starting edge. On a random share of transfers it drops `in_valid` on the second beat. The bench then requires the exact reordered vector and the exact beat timing. Directed transfers cover the reserved mode value and broadcast from the first and the last lane.

// File: rtl/oeg_net.sv
module oeg_net #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_mode,
  input  logic [$clog2(L)-1:0] in_src,
  input  logic [L*W-1:0]       in_data,
  output logic                 out_valid,
  output logic                 out_done,
  output logic [L*W-1:0]       out_data
);
  localparam int N  = 2 * L;
  localparam int SW = $clog2(N);
  localparam int LW = $clog2(L);

  typedef enum logic [2:0] {IDLE, LOAD, SHIFT, OUT0, OUT1} ph_t;

  ph_t           ph;
  logic [SW-1:0] step;
  logic [1:0]    mode_q;
  logic [LW-1:0] src_q;
  logic [W-1:0]  ring [N];
  logic [W-1:0]  dst  [N];
  logic          acc;

  function automatic logic [SW-1:0] elem_of(int p, logic [1:0] m, logic [LW-1:0] s);
    case (m)
      2'b01:   return (p < L) ? SW'(2 * p) : SW'(2 * (p - L) + 1);
      2'b10:   return (p < L) ? SW'(s) : SW'(s) + SW'(L);
      default: return SW'(p);
    endcase
  endfunction

  assign in_ready  = (ph == IDLE);
  assign acc       = in_valid && in_ready;
  assign out_valid = (ph == OUT0) || (ph == OUT1);
  assign out_done  = (ph == OUT1);

  for (genvar k = 0; k < L; k++) begin : g_lane
    assign out_data[k*W +: W] = (ph == OUT0) ? dst[k] :
                                (ph == OUT1) ? dst[k+L] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= IDLE;
      step   <= '0;
      mode_q <= '0;
      src_q  <= '0;
    end else begin
      case (ph)
        IDLE: if (acc) begin
          mode_q <= in_mode;
          src_q  <= in_src;
          ph     <= LOAD;
        end
        LOAD: begin
          step <= '0;
          ph   <= SHIFT;
        end
        SHIFT: begin
          step <= step + 1'b1;
          if (step == SW'(N - 1)) ph <= OUT0;
        end
        OUT0:    ph <= OUT1;
        OUT1:    ph <= IDLE;
        default: ph <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        ring[p] <= '0;
        dst[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < N; p++) begin
        if ((p < L) ? acc : (ph == LOAD))
          ring[p] <= in_data[(p % L)*W +: W];
        else if (ph == SHIFT)
          ring[p] <= ring[(p + N - 1) % N];
        if (ph == SHIFT && step == SW'(p) - elem_of(p, mode_q, src_q))
          dst[p] <= ring[p];
      end
    end
  end
endmodule

module oeg_net_chk #(
  parameter int W = 16,
  parameter int L = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_done,
  input logic [L*W-1:0] out_data
);
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
  assert_busy_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_done_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> out_valid);
  assert_done_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(out_valid && !out_done));
  assert_ready_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> in_ready);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind oeg_net oeg_net_chk #(.W(W), .L(L)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_done(out_done), .out_data(out_data)
);

// File: tb/oeg_net_bench.sv
`timescale 1ns/1ps
module oeg_net_bench;
  localparam int W = 16;
  localparam int L = 4;
  localparam int N = 2 * L;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           in_valid = 0;
  logic           in_ready;
  logic [1:0]     in_mode = 0;
  logic [1:0]     in_src = 0;
  logic [L*W-1:0] in_data = 0;
  logic           out_valid, out_done;
  logic [L*W-1:0] out_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  oeg_net #(.W(W), .L(L)) u_oeg_net (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_src(in_src), .in_data(in_data),
    .out_valid(out_valid), .out_done(out_done), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int src_elem(int p, int m, int s);
    if (m == 1) return (p < L) ? 2 * p : 2 * (p - L) + 1;
    if (m == 2) return (p < L) ? s : s + L;
    return p;
  endfunction

  task automatic xfer(input int m, input int s, input logic [W-1:0] x [N], input bit drop2);
    logic [L*W-1:0] e0, e1;
    string mt;
    mt = (m == 1) ? "R5,R3" : (m == 2) ? "R6,R3" : "R4,R3";
    for (int k = 0; k < L; k++) begin
      e0[k*W +: W] = x[src_elem(k, m, s)];
      e1[k*W +: W] = x[src_elem(k + L, m, s)];
    end
    @(negedge clk);
    in_valid = 1; in_mode = 2'(m); in_src = 2'(s);
    for (int k = 0; k < L; k++) in_data[k*W +: W] = x[k];
    chk(in_ready == 1, "R2 ready before start", 64'(in_ready), 1);
    @(posedge clk);
    for (int j = 0; j <= 11; j++) begin
      @(negedge clk);
      if (j == 0) begin
        for (int k = 0; k < L; k++) in_data[k*W +: W] = x[k + L];
        in_valid = !drop2;
      end else begin
        in_data = {$urandom, $urandom};
        in_valid = (j < 10);
      end
      in_mode = 2'($urandom); in_src = 2'($urandom);
      if (j <= 8) begin
        chk(in_ready == 0, "R9 held off", 64'(in_ready), 0);
        if (j >= 1) begin
          chk(out_valid == 0 && out_done == 0, "R7 no early beat", 64'({out_valid, out_done}), 0);
          chk(out_data == '0, "R8 zero data", out_data, 0);
        end
      end else if (j == 9) begin
        chk(out_valid == 1 && out_done == 0, "R7 beat0 flags", 64'({out_valid, out_done}), 2);
        chk(out_data == e0, {mt, " beat0"}, out_data, e0);
      end else if (j == 10) begin
        chk(out_valid == 1 && out_done == 1, "R7 beat1 flags", 64'({out_valid, out_done}), 3);
        chk(out_data == e1, {mt, " beat1"}, out_data, e1);
      end else begin
        chk(in_ready == 1 && out_valid == 0, "R9 ready again", 64'({in_ready, out_valid}), 2);
        chk(out_data == '0, "R8 zero after", out_data, 0);
      end
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] x [N];
    void'($urandom(32'd1234));
    #1;
    chk(in_ready == 1 && out_valid == 0 && out_done == 0, "R1 reset flags",
        64'({in_ready, out_valid, out_done}), 4);
    chk(out_data == '0, "R1 reset data", out_data, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1 idle after reset", 64'({in_ready, out_valid}), 2);
    for (int i = 0; i < N; i++) x[i] = W'(16'h1000 + i);
    xfer(0, 0, x, 0);
    xfer(3, 1, x, 1);
    xfer(1, 0, x, 0);
    xfer(2, 0, x, 0);
    xfer(2, 3, x, 1);
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++) x[i] = W'($urandom);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      xfer(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), x, bit'($urandom));
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule